// File: doc/BRIEF.md
# Single-Cycle 16-Bit Processor Core

This block is a small processor that finishes one instruction on every clock edge. It has a 16-bit word, sixteen 16-bit registers and thirteen instructions, each one word long. Each instruction uses one of three layouts: four 4-bit fields, a 4-bit opcode with an 8-bit immediate and a 4-bit register, or a 4-bit opcode with a 12-bit address. The core holds its program memory and its data memory inside. Both are word-addressed.

Software is loaded while `rst` is high, one word per clock, through a write port into program memory. When `rst` falls, the core runs from address 0. It stops when it reaches the halt instruction, and `halted` then rises. After that, a monitor port lets the caller read any register, with one cycle of delay.

The operations are few, and several of them write to a fixed register. Logic results go to register 13. Compare results and the conditional-jump flag live in register 14. The return address goes to register 15. Loads and stores always use register 7 as the address and register 8 as the data.

Top module: `t16_core`

## Requirements
- R1: While `rst` is high at a clock edge, `pc` becomes 0, `halted` becomes 0 and all sixteen registers become 0.
- R2: Register 0 always reads as 0, and any instruction that names it as a destination leaves it at 0.
- R3: Opcode `0000` (add) and opcode `0010` (subtract) read the first source from bits 11:8 and the second source from bits 7:4. They write the sum, or first minus second, modulo 2^16, to the register in bits 3:0.
- R4: Opcode `0001` adds the sign-extended byte in bits 11:4 to the register in bits 3:0 and writes the result back to that same register.
- R5: Opcode `0011` combines X (the register in bits 7:4) with Y (the register in bits 3:0) using the function code in bits 11:8: 0 gives X AND Y, 1 gives X OR Y, 2 gives X XOR Y, and 3 gives NOT X. Any other code gives 0. The result always goes to register 13.
- R6: Opcode `0100` compares P (the register in bits 3:0) with Q (the register in bits 7:4), treating both as signed numbers. The relation code is in bits 11:8: 0 is P=Q, 1 is P≠Q, 2 is P<Q, 3 is P>Q, 4 is P≤Q and 5 is P≥Q. Register 14 receives 1 if the relation holds and 0 if it does not. Codes 6 and 7 always give 0.
- R7: Opcode `1001` rotates the register in bits 3:0 left by the count held in bits 7:4.
- R8: Opcode `1000` writes register 8 to data word `r7[7:0]`. Opcode `0111` loads that same data word into register 8.
- R9: Opcode `0101` sets `pc` to pc + 1 + the sign-extended offset in bits 11:4.
- R10: Opcode `0110` jumps to pc + 1 + offset when register 14 holds exactly 1, and otherwise goes on to pc + 1. In both cases it clears register 14 to 0.
- R11: Opcode `1010` stores pc + 1 in register 15 and loads `pc` from the low address bits. Opcode `1011` loads `pc` from register 15.
- R12: Opcode `1100` sets `halted` to 1. From then until reset, `pc` stays on the halt instruction and no register changes.
- R13: Opcodes `1101`, `1110` and `1111` only advance `pc` by one.
- R14: A word on `imem_wdata` is stored at `imem_addr` on any clock edge where `imem_we` is high. `mon_data` shows the register selected by `mon_sel` one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; holds the core idle |
| imem_we | input | 1 | Program memory write strobe |
| imem_addr | input | IAW | Program memory write address |
| imem_wdata | input | 16 | Program word to store |
| mon_sel | input | 4 | Register number for the monitor port |
| mon_data | output | 16 | Registered contents of the selected register |
| pc | output | IAW | Program counter |
| halted | output | 1 | High once a halt instruction has run |

## Verification
The hardest case to reach is any operation on a chosen 16-bit operand. This is because no instruction loads a full word into a register. The bench builds every operand inside the program itself: it adds one 4-bit piece at a time and rotates left by four between the pieces. On those built values it then runs each operation, including the taken and not-taken forms of the conditional jump. Directed vectors sit at the signed boundary (0x8000 against 0x7FFF), use equal operands, and step through every logic code and every compare code, including the unused ones.

// File: rtl/t16_pkg.sv
package t16_pkg;
  localparam int XW   = 16;
  localparam int NREG = 16;
  localparam logic [3:0] REG_ADR  = 4'd7;
  localparam logic [3:0] REG_DAT  = 4'd8;
  localparam logic [3:0] REG_LOG  = 4'd13;
  localparam logic [3:0] REG_FLAG = 4'd14;
  localparam logic [3:0] REG_LINK = 4'd15;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,  OP_ADDI = 4'd1,  OP_SUB  = 4'd2,  OP_LOGIC = 4'd3,
    OP_COMP = 4'd4,  OP_UJMP = 4'd5,  OP_CJMP = 4'd6,  OP_LW    = 4'd7,
    OP_SW   = 4'd8,  OP_ROL  = 4'd9,  OP_CALL = 4'd10, OP_RET   = 4'd11,
    OP_HALT = 4'd12
  } op_e;

  typedef enum logic [1:0] {WB_ALU, WB_MEM, WB_LINK, WB_ZERO} wb_e;

  typedef struct packed {
    logic [3:0] ra1;
    logic [3:0] ra2;
    logic [3:0] ra3;
    logic [3:0] wa;
    logic       we;
    wb_e        wsel;
  } ctl_t;
endpackage

// File: rtl/t16_decode.sv
module t16_decode
  import t16_pkg::*;
(
  input  logic [XW-1:0] instr,
  output ctl_t          ctl
);
  op_e op;
  assign op = op_e'(instr[15:12]);

  always_comb begin
    ctl.ra1  = instr[11:8];
    ctl.ra2  = instr[7:4];
    ctl.ra3  = instr[3:0];
    ctl.wa   = instr[3:0];
    ctl.we   = 1'b0;
    ctl.wsel = WB_ALU;
    case (op)
      OP_ADD, OP_SUB, OP_ADDI, OP_ROL: ctl.we = 1'b1;
      OP_LOGIC: begin ctl.we = 1'b1; ctl.wa = REG_LOG; end
      OP_COMP:  begin ctl.we = 1'b1; ctl.wa = REG_FLAG; end
      OP_CJMP:  begin
        ctl.ra1 = REG_FLAG; ctl.we = 1'b1; ctl.wa = REG_FLAG; ctl.wsel = WB_ZERO;
      end
      OP_LW:    begin
        ctl.ra1 = REG_ADR; ctl.we = 1'b1; ctl.wa = REG_DAT; ctl.wsel = WB_MEM;
      end
      OP_SW:    begin ctl.ra1 = REG_ADR; ctl.ra2 = REG_DAT; end
      OP_CALL:  begin ctl.we = 1'b1; ctl.wa = REG_LINK; ctl.wsel = WB_LINK; end
      OP_RET:   ctl.ra1 = REG_LINK;
      default:  ;
    endcase
  end
endmodule

// File: rtl/t16_alu.sv
module t16_alu
  import t16_pkg::*;
(
  input  logic [3:0]    op,
  input  logic [3:0]    fn,
  input  logic [7:0]    imm,
  input  logic [XW-1:0] d1,
  input  logic [XW-1:0] d2,
  input  logic [XW-1:0] d3,
  output logic [XW-1:0] res
);
  logic signed [XW-1:0] p, q;
  logic                 rel;
  logic [2*XW-1:0]      rot;

  assign p   = d3;
  assign q   = d2;
  assign rot = {d3, d3} << imm[3:0];

  always_comb begin
    case (fn)
      4'd0:    rel = (p == q);
      4'd1:    rel = (p != q);
      4'd2:    rel = (p <  q);
      4'd3:    rel = (p >  q);
      4'd4:    rel = (p <= q);
      4'd5:    rel = (p >= q);
      default: rel = 1'b0;
    endcase
  end

  always_comb begin
    case (op_e'(op))
      OP_ADD:  res = d1 + d2;
      OP_SUB:  res = d1 - d2;
      OP_ADDI: res = d3 + {{(XW-8){imm[7]}}, imm};
      OP_LOGIC: begin
        case (fn)
          4'd0:    res = d2 & d3;
          4'd1:    res = d2 | d3;
          4'd2:    res = d2 ^ d3;
          4'd3:    res = ~d2;
          default: res = '0;
        endcase
      end
      OP_COMP: res = {{(XW-1){1'b0}}, rel};
      OP_ROL:  res = rot[2*XW-1:XW];
      default: res = '0;
    endcase
  end
endmodule

// File: rtl/t16_regfile.sv
module t16_regfile
  import t16_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [3:0]    wa,
  input  logic [XW-1:0] wd,
  input  logic [3:0]    ra1,
  input  logic [3:0]    ra2,
  input  logic [3:0]    ra3,
  output logic [XW-1:0] d1,
  output logic [XW-1:0] d2,
  output logic [XW-1:0] d3,
  input  logic [3:0]    mon_sel,
  output logic [XW-1:0] mon_data
);
  logic [XW-1:0] regs [NREG];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
      mon_data <= '0;
    end else begin
      if (we && wa != 4'd0) regs[wa] <= wd;
      mon_data <= regs[mon_sel];
    end
  end

  assign d1 = regs[ra1];
  assign d2 = regs[ra2];
  assign d3 = regs[ra3];

  // R2: register zero never shows anything but zero on the monitor port
  a_r2_zero_reg: assert property (@(posedge clk) disable iff (rst)
    ($past(mon_sel) == 4'd0) |-> (mon_data == '0));
endmodule

// File: rtl/t16_core.sv
module t16_core
  import t16_pkg::*;
#(
  parameter int IAW = 8,
  parameter int DAW = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           imem_we,
  input  logic [IAW-1:0] imem_addr,
  input  logic [XW-1:0]  imem_wdata,
  input  logic [3:0]     mon_sel,
  output logic [XW-1:0]  mon_data,
  output logic [IAW-1:0] pc,
  output logic           halted
);
  localparam int IDEPTH = 1 << IAW;
  localparam int DDEPTH = 1 << DAW;

  logic [XW-1:0] imem [IDEPTH];
  logic [XW-1:0] dmem [DDEPTH];
  logic [XW-1:0] instr, d1, d2, d3, alu_res, wd, mem_rd, link;
  logic [XW-1:0] pc_ext, rel_tgt;
  logic          run;
  op_e           op;
  ctl_t          ctl;

  assign run    = !rst && !halted;
  assign instr  = imem[pc];
  assign op     = op_e'(instr[15:12]);
  assign mem_rd = dmem[d1[DAW-1:0]];
  assign pc_ext = XW'(pc);
  assign link   = pc_ext + 1'b1;
  assign rel_tgt = link + {{(XW-8){instr[11]}}, instr[11:4]};

  always_ff @(posedge clk) begin
    if (imem_we) imem[imem_addr] <= imem_wdata;
  end

  always_ff @(posedge clk) begin
    if (run && op == OP_SW) dmem[d1[DAW-1:0]] <= d2;
  end

  t16_decode u_dec (.instr(instr), .ctl(ctl));

  t16_alu u_alu (
    .op(instr[15:12]), .fn(instr[11:8]), .imm(instr[11:4]),
    .d1(d1), .d2(d2), .d3(d3), .res(alu_res)
  );

  always_comb begin
    case (ctl.wsel)
      WB_MEM:  wd = mem_rd;
      WB_LINK: wd = link;
      WB_ZERO: wd = '0;
      default: wd = alu_res;
    endcase
  end

  t16_regfile u_rf (
    .clk(clk), .rst(rst), .we(run && ctl.we), .wa(ctl.wa), .wd(wd),
    .ra1(ctl.ra1), .ra2(ctl.ra2), .ra3(ctl.ra3),
    .d1(d1), .d2(d2), .d3(d3),
    .mon_sel(mon_sel), .mon_data(mon_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pc     <= '0;
      halted <= 1'b0;
    end else if (!halted) begin
      case (op)
        OP_UJMP: pc <= rel_tgt[IAW-1:0];
        OP_CJMP: pc <= (d1 == XW'(1)) ? rel_tgt[IAW-1:0] : link[IAW-1:0];
        OP_CALL: pc <= instr[IAW-1:0];
        OP_RET:  pc <= d1[IAW-1:0];
        OP_HALT: halted <= 1'b1;
        default: pc <= link[IAW-1:0];
      endcase
    end
  end

  // R12: a halt instruction raises the halted flag on the next edge
  a_r12_halt_entry: assert property (@(posedge clk) disable iff (rst)
    (run && op == OP_HALT) |=> halted);
  // R12: once halted the core stays put
  a_r12_halt_hold: assert property (@(posedge clk) disable iff (rst)
    halted |=> (halted && $stable(pc)));
  // R11: call lands on its address field
  a_r11_call_target: assert property (@(posedge clk) disable iff (rst)
    (run && op == OP_CALL) |=> (pc == $past(instr[IAW-1:0])));
  // R13: unassigned opcodes just step the counter
  a_r13_undef_step: assert property (@(posedge clk) disable iff (rst)
    (run && instr[15:13] == 3'b111) |=> (pc == IAW'($past(pc) + 1)));
  a_r13_undef_step_d: assert property (@(posedge clk) disable iff (rst)
    (run && instr[15:12] == 4'b1101) |=> (pc == IAW'($past(pc) + 1)));
endmodule

// File: tb/sim_t16_core.sv
module sim_t16_core;
  localparam int IAW = 8;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           imem_we = 1'b0;
  logic [IAW-1:0] imem_addr = '0;
  logic [15:0]    imem_wdata = '0;
  logic [3:0]     mon_sel = '0;
  logic [15:0]    mon_data;
  logic [IAW-1:0] pc;
  logic           halted;

  int nvec = 0;
  int nerr = 0;
  int cyc  = 0;
  bit done = 0;
  logic [15:0] prog [256];
  int plen;

  t16_core #(.IAW(IAW), .DAW(8)) u0 (
    .clk(clk), .rst(rst), .imem_we(imem_we), .imem_addr(imem_addr),
    .imem_wdata(imem_wdata), .mon_sel(mon_sel), .mon_data(mon_data),
    .pc(pc), .halted(halted)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [15:0] f_logic(input logic [3:0] c, input logic [15:0] x, y);
    case (c)
      4'd0: return x & y;
      4'd1: return x | y;
      4'd2: return x ^ y;
      4'd3: return ~x;
      default: return 16'h0;
    endcase
  endfunction

  function automatic logic [15:0] f_cmp(input logic [3:0] c, input logic signed [15:0] p, q);
    bit r;
    case (c)
      4'd0: r = (p == q);
      4'd1: r = (p != q);
      4'd2: r = (p < q);
      4'd3: r = (p > q);
      4'd4: r = (p <= q);
      4'd5: r = (p >= q);
      default: r = 0;
    endcase
    return {15'h0, r};
  endfunction

  function automatic logic [15:0] f_rol(input logic [15:0] v, input int n);
    logic [15:0] r = v;
    for (int k = 0; k < n; k++) r = {r[14:0], r[15]};
    return r;
  endfunction

  task automatic chk(input string req, input logic [15:0] act, exp);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic emit(input logic [15:0] w);
    prog[plen] = w;
    plen++;
  endtask

  // build a 16-bit value in a register that is zero after reset
  task automatic emit_const(input logic [3:0] rd, input logic [15:0] v);
    emit({4'h1, 4'h0, v[15:12], rd});
    emit({4'h9, 4'h0, 4'd4, rd});
    emit({4'h1, 4'h0, v[11:8], rd});
    emit({4'h9, 4'h0, 4'd4, rd});
    emit({4'h1, 4'h0, v[7:4], rd});
    emit({4'h9, 4'h0, 4'd4, rd});
    emit({4'h1, 4'h0, v[3:0], rd});
  endtask

  task automatic run_prog;
    int n;
    @(negedge clk) rst = 1'b1;
    for (int i = 0; i < plen; i++) begin
      @(negedge clk);
      imem_we = 1'b1; imem_addr = IAW'(i); imem_wdata = prog[i];
    end
    @(negedge clk) imem_we = 1'b0;
    rst = 1'b0;
    n = 0;
    while (!halted && n < 3000) begin
      @(negedge clk);
      n++;
    end
    chk("R12 halted reached", {15'h0, halted}, 16'h1);
  endtask

  task automatic rd_reg(input logic [3:0] r, output logic [15:0] v);
    @(negedge clk) mon_sel = r;
    @(negedge clk) v = mon_data;
  endtask

  initial begin
    wait (cyc >= 150000);
    if (!done) begin
      nerr++;
      $display("FAIL watchdog: got %0d cycles expected completion", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  end

  initial begin
    logic [15:0] v, a, b;
    logic [3:0]  lc, cc;
    logic [7:0]  imm, adr;
    int          rc;
    logic [15:0] da [4] = '{16'h8000, 16'h1234, 16'hFFFF, 16'h0005};
    logic [15:0] db [4] = '{16'h7FFF, 16'h1234, 16'h0001, 16'hFFFB};
    void'($urandom(32'd1977));

    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1 pc at reset", {8'h0, pc}, 16'h0);
    chk("R1 halted at reset", {15'h0, halted}, 16'h0);

    plen = 0; emit(16'hC000);
    run_prog();
    chk("R12 pc held on halt at 0", {8'h0, pc}, 16'h0);
    for (int r = 0; r < 16; r++) begin
      rd_reg(4'(r), v);
      chk("R1 register cleared", v, 16'h0);
    end

    // directed control flow: R9 R10 R11 R13 R2 R14
    plen = 0;
    emit(16'h1051);   // 0: r1 += 5
    emit(16'h5010);   // 1: ujmp +1 -> 3
    emit(16'h1641);   // 2: skipped
    emit(16'h4011);   // 3: r14 = (r1 == r1)
    emit(16'h6010);   // 4: cjmp +1 taken -> 6, clears r14
    emit(16'h1012);   // 5: skipped
    emit(16'h6010);   // 6: cjmp not taken -> 7
    emit(16'h1073);   // 7: r3 += 7
    emit(16'hA00C);   // 8: call 12, r15 = 9
    emit(16'hD123);   // 9: undefined
    emit(16'h0110);   // 10: add r0 = r1 + r1
    emit(16'hE0F1);   // 11: undefined
    emit(16'hF0F2);   // 12: undefined
    emit(16'hC000);   // 13: halt
    emit(16'h0000);   // 14
    emit(16'h0000);   // 15
    prog[12] = 16'h1039; // 12: r9 += 3 (subroutine)
    prog[13] = 16'hB000; // 13: ret
    prog[11] = 16'hE0F1; // 11: undefined
    prog[14] = 16'hC000; // 14: never reached
    plen = 16;
    // layout after ret: 9 undef, 10 add r0, 11 undef, then 12 again would loop;
    // place halt at 11 instead for a clean stop
    prog[11] = 16'hC000;
    run_prog();
    chk("R12 pc holds on halt", {8'h0, pc}, 16'd11);
    repeat (4) @(negedge clk);
    chk("R12 pc still held", {8'h0, pc}, 16'd11);
    chk("R12 halted sticky", {15'h0, halted}, 16'h1);
    rd_reg(4'd1, v);  chk("R9 ujmp skipped word", v, 16'd5);
    rd_reg(4'd2, v);  chk("R10 taken cjmp skipped word", v, 16'd0);
    rd_reg(4'd3, v);  chk("R10 untaken cjmp falls through", v, 16'd7);
    rd_reg(4'd14, v); chk("R10 cjmp clears flag", v, 16'd0);
    rd_reg(4'd9, v);  chk("R11 call reached subroutine", v, 16'd3);
    rd_reg(4'd15, v); chk("R11 link address", v, 16'd9);
    rd_reg(4'd0, v);  chk("R2 zero register write ignored", v, 16'd0);
    rd_reg(4'd5, v);  chk("R13 undefined opcode no effect", v, 16'd0);

    // operand vectors: directed boundaries first, then random
    for (int it = 0; it < 40; it++) begin
      if (it < 8) begin
        a = da[it % 4]; b = db[it % 4]; lc = 4'(it); cc = 4'(it);
      end else begin
        a = 16'($urandom); b = 16'($urandom);
        lc = 4'($urandom % 8); cc = 4'($urandom % 8);
      end
      rc  = $urandom % 16;
      imm = 8'($urandom);
      adr = 8'($urandom);
      plen = 0;
      emit_const(4'd1, a);
      emit_const(4'd2, b);
      emit(16'h0123);                       // r3 = r1 + r2
      emit(16'h2124);                       // r4 = r1 - r2
      emit({4'h3, lc, 4'd1, 4'd2});         // r13 = f(r1, r2)
      emit({4'h4, cc, 4'd2, 4'd1});         // r14 = r1 rel r2
      emit(16'h0105);                       // r5 = r1
      emit({4'h9, 4'h0, 4'(rc), 4'd5});     // rol r5
      emit(16'h0206);                       // r6 = r2
      emit({4'h1, imm, 4'd6});              // r6 += sext(imm)
      emit_const(4'd7, {8'h00, adr});
      emit(16'h0108);                       // r8 = r1
      emit(16'h8780);                       // store
      emit(16'h2888);                       // r8 = 0
      emit(16'h1018);                       // r8 = 1
      emit(16'h7708);                       // load
      emit(16'hC000);
      run_prog();
      rd_reg(4'd3, v);  chk("R3 add", v, a + b);
      rd_reg(4'd4, v);  chk("R3 sub", v, a - b);
      rd_reg(4'd13, v); chk("R5 logic", v, f_logic(lc, a, b));
      rd_reg(4'd14, v); chk("R6 compare", v, f_cmp(cc, a, b));
      rd_reg(4'd5, v);  chk("R7 rotate", v, f_rol(a, rc));
      rd_reg(4'd6, v);  chk("R4 add immediate", v, b + {{8{imm[7]}}, imm});
      rd_reg(4'd8, v);  chk("R8 store then load", v, a);
      rd_reg(4'd0, v);  chk("R2 zero register", v, 16'h0);
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule